// File: doc/BRIEF.md
# Masked Serial Bit Correlator

The block scores how closely two 64-bit words agree. Three shift registers are filled one bit per rising edge of their own clocks: a probe word, a reference word and a per-position enable mask. A snapshot register holds a copy of the reference word. The copy is taken on the core clock while a capture strobe is high. The reference shift register can then take in its next word while the comparison keeps running against the snapshot.

On every core clock the block counts the positions where the probe and the snapshot agree and the mask bit is 1. It registers this count as the score. It also registers a match flag, which is set when the score is at least a programmable threshold. The threshold is held in a register and loaded from an input bus. Each shift register drives the bit leaving its top end on a serial output, so several blocks can be chained. The shift clocks are assumed to be quiet around core clock edges. Synchronising the score across clock domains is not part of this block.

Top module: `masked_correlator`

## Requirements
- R1: On each rising edge of `clk_a` the probe register moves up one place: `a_in` enters bit 0 and every bit i moves to bit i+1. `a_sout` always shows bit 63, so a word shifted in with bit 63 first reappears on `a_sout` in the same order.
- R2: The reference register behaves the same way on rising edges of `clk_b`, with `b_in` as input and `b_sout` as bit 63.
- R3: The mask register behaves the same way on rising edges of `clk_m`, with `m_in` as input and `m_sout` as bit 63. A mask bit of 1 lets that position take part in the count.
- R4: On a rising `clk` edge with `load_c` high, the snapshot takes the reference register's contents. With `load_c` low the snapshot holds, so shifting new reference data does not change the score.
- R5: One `clk` edge after its inputs settle, `score_o` equals the number of positions where the probe bit equals the snapshot bit and the mask bit is 1. The score spans 0 to 64, and a full 64-position match reads 64.
- R6: On a rising `clk` edge with `thr_load` high, the threshold register takes `thr_in`. With `thr_load` low, changes on `thr_in` have no effect.
- R7: `flag_o` is registered on the same edge as `score_o` and is 1 exactly when that score is greater than or equal to the threshold in force at that edge.
- R8: While `rst_n` is low, all registers clear and `score_o` and `flag_o` read 0.
- R9: With an all-zero mask the score is 0, and the flag is set only when the threshold is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock for snapshot, threshold, score and flag |
| rst_n | input | 1 | Asynchronous active-low reset for all registers |
| clk_a | input | 1 | Probe shift clock |
| a_in | input | 1 | Probe serial data in |
| a_sout | output | 1 | Probe bit 63 |
| clk_b | input | 1 | Reference shift clock |
| b_in | input | 1 | Reference serial data in |
| b_sout | output | 1 | Reference bit 63 |
| clk_m | input | 1 | Mask shift clock |
| m_in | input | 1 | Mask serial data in |
| m_sout | output | 1 | Mask bit 63 |
| load_c | input | 1 | Snapshot capture strobe |
| thr_load | input | 1 | Threshold load strobe |
| thr_in | input | 7 | Threshold value to load |
| score_o | output | 7 | Registered masked match count |
| flag_o | output | 1 | Registered score-at-or-above-threshold flag |

## Verification
A wrong bit in any shift register reaches the ports in two ways. It appears on the serial output when it reaches bit 63, at most 64 shift clocks later. If it sits at an enabled position, it also moves the score by one on the next core edge. A bad snapshot or threshold register shows on the following core edge as a wrong score or a flipped flag. The bench therefore reads back every word it replaces through the serial outputs, and it compares score and flag two core edges after each capture or threshold load.

// File: rtl/corr_pkg.sv
package corr_pkg;

    // Width needed to count from 0 to n inclusive
    function automatic int unsigned count_width(input int unsigned n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/corr_shift_reg.sv
module corr_shift_reg #(
    parameter int WIDTH = 64
) (
    input  logic             sclk,
    input  logic             rst_n,
    input  logic             din,
    output logic [WIDTH-1:0] q,
    output logic             sout
);

    logic [WIDTH-1:0] bits_q;

    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else begin
            bits_q <= {bits_q[WIDTH-2:0], din};
        end
    end

    assign q    = bits_q;
    assign sout = bits_q[WIDTH-1];

endmodule

// File: rtl/corr_popcount.sv
module corr_popcount #(
    parameter int WIDTH = 64,
    localparam int SW   = corr_pkg::count_width(WIDTH)
) (
    input  logic [WIDTH-1:0] probe,
    input  logic [WIDTH-1:0] snap,
    input  logic [WIDTH-1:0] enable,
    output logic [SW-1:0]    count
);

    logic [WIDTH-1:0] hits;

    assign hits = ~(probe ^ snap) & enable;

    always_comb begin
        count = '0;
        for (int i = 0; i < WIDTH; i++) begin
            count = count + SW'(hits[i]);
        end
    end

endmodule

// File: rtl/corr_score_unit.sv
module corr_score_unit #(
    parameter int WIDTH = 64,
    localparam int SW   = corr_pkg::count_width(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_c,
    input  logic [WIDTH-1:0] ref_word,
    input  logic             thr_load,
    input  logic [SW-1:0]    thr_in,
    input  logic [SW-1:0]    match_cnt,
    output logic [WIDTH-1:0] snap_q,
    output logic [SW-1:0]    thr_q,
    output logic [SW-1:0]    score_q,
    output logic             flag_q
);

    // Snapshot of the reference word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else if (load_c) begin
            snap_q <= ref_word;
        end
    end

    // Threshold register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_q <= '0;
        end else if (thr_load) begin
            thr_q <= thr_in;
        end
    end

    // Score and flag share one edge and use the threshold held before it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            score_q <= '0;
            flag_q  <= 1'b0;
        end else begin
            score_q <= match_cnt;
            flag_q  <= (match_cnt >= thr_q);
        end
    end

endmodule

// File: rtl/masked_correlator.sv
module masked_correlator #(
    parameter int WIDTH = 64,
    localparam int SW   = corr_pkg::count_width(WIDTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clk_a,
    input  logic          a_in,
    output logic          a_sout,
    input  logic          clk_b,
    input  logic          b_in,
    output logic          b_sout,
    input  logic          clk_m,
    input  logic          m_in,
    output logic          m_sout,
    input  logic          load_c,
    input  logic          thr_load,
    input  logic [SW-1:0] thr_in,
    output logic [SW-1:0] score_o,
    output logic          flag_o
);

    logic [WIDTH-1:0] a_q;
    logic [WIDTH-1:0] b_q;
    logic [WIDTH-1:0] m_q;
    logic [WIDTH-1:0] c_q;
    logic [SW-1:0]    thr_q;
    logic [SW-1:0]    match_cnt;

    logic [2:0]       sclk_v;
    logic [2:0]       sdin_v;
    logic [2:0]       sout_v;
    logic [WIDTH-1:0] word_v [3];

    assign sclk_v = {clk_m, clk_b, clk_a};
    assign sdin_v = {m_in, b_in, a_in};

    for (genvar g = 0; g < 3; g++) begin : g_chain
        corr_shift_reg #(.WIDTH(WIDTH)) sr_i (
            .sclk (sclk_v[g]),
            .rst_n(rst_n),
            .din  (sdin_v[g]),
            .q    (word_v[g]),
            .sout (sout_v[g])
        );
    end

    assign a_q    = word_v[0];
    assign b_q    = word_v[1];
    assign m_q    = word_v[2];
    assign a_sout = sout_v[0];
    assign b_sout = sout_v[1];
    assign m_sout = sout_v[2];

    corr_popcount #(.WIDTH(WIDTH)) pop_i (
        .probe (a_q),
        .snap  (c_q),
        .enable(m_q),
        .count (match_cnt)
    );

    corr_score_unit #(.WIDTH(WIDTH)) score_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_c   (load_c),
        .ref_word (b_q),
        .thr_load (thr_load),
        .thr_in   (thr_in),
        .match_cnt(match_cnt),
        .snap_q   (c_q),
        .thr_q    (thr_q),
        .score_q  (score_o),
        .flag_q   (flag_o)
    );

endmodule

// File: rtl/corr_checker.sv
module corr_checker #(
    parameter int WIDTH = 64,
    localparam int SW   = corr_pkg::count_width(WIDTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clk_a,
    input logic             a_in,
    input logic             clk_m,
    input logic             m_in,
    input logic [WIDTH-1:0] a_q,
    input logic [WIDTH-1:0] b_q,
    input logic [WIDTH-1:0] c_q,
    input logic [WIDTH-1:0] m_q,
    input logic [SW-1:0]    thr_q,
    input logic             load_c,
    input logic             thr_load,
    input logic [SW-1:0]    thr_in,
    input logic [SW-1:0]    score_o,
    input logic             flag_o
);

    p_shift_a_r1: assert property (@(posedge clk_a) disable iff (!rst_n)
        1'b1 |=> (a_q[0] == $past(a_in)) && (a_q[WIDTH-1:1] == $past(a_q[WIDTH-2:0])));

    p_shift_m_r3: assert property (@(posedge clk_m) disable iff (!rst_n)
        1'b1 |=> (m_q[0] == $past(m_in)));

    p_snap_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_c |=> (c_q == $past(b_q)));

    p_snap_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !load_c |=> $stable(c_q));

    p_score_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (32'(score_o) <= $past($countones(m_q))));

    p_thr_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        thr_load |=> (thr_q == $past(thr_in)));

    p_thr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !thr_load |=> $stable(thr_q));

    p_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (flag_o == (score_o >= $past(thr_q))));

    p_mask_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (m_q == '0) |=> (score_o == '0));

endmodule

bind masked_correlator corr_checker #(.WIDTH(WIDTH)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clk_a   (clk_a),
    .a_in    (a_in),
    .clk_m   (clk_m),
    .m_in    (m_in),
    .a_q     (a_q),
    .b_q     (b_q),
    .c_q     (c_q),
    .m_q     (m_q),
    .thr_q   (thr_q),
    .load_c  (load_c),
    .thr_load(thr_load),
    .thr_in  (thr_in),
    .score_o (score_o),
    .flag_o  (flag_o)
);

// File: tb/masked_correlator_tb.sv
`timescale 1ns/1ps
module masked_correlator_tb_top;

    localparam int W  = 64;
    localparam int SW = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clk_a = 1'b0, a_in = 1'b0;
    logic clk_b = 1'b0, b_in = 1'b0;
    logic clk_m = 1'b0, m_in = 1'b0;
    logic load_c = 1'b0, thr_load = 1'b0;
    logic [SW-1:0] thr_in = '0;
    logic a_sout, b_sout, m_sout, flag_o;
    logic [SW-1:0] score_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [W-1:0] cur_a = '0, cur_b = '0, cur_m = '0, cur_c = '0;
    int cur_thr = 0;

    always #4 clk = ~clk;

    masked_correlator #(.WIDTH(W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .clk_a(clk_a), .a_in(a_in), .a_sout(a_sout),
        .clk_b(clk_b), .b_in(b_in), .b_sout(b_sout),
        .clk_m(clk_m), .m_in(m_in), .m_sout(m_sout),
        .load_c(load_c), .thr_load(thr_load), .thr_in(thr_in),
        .score_o(score_o), .flag_o(flag_o)
    );

    function automatic int model_score(input logic [W-1:0] a, input logic [W-1:0] c,
                                       input logic [W-1:0] m);
        int n = 0;
        for (int i = 0; i < W; i++) if (m[i] && (a[i] == c[i])) n++;
        return n;
    endfunction

    task automatic check(input bit ok, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s", msg);
        end
    endtask

    // sel: 0 probe, 1 reference, 2 mask; old word must come back on the serial output
    task automatic shift_word(input int sel, input logic [W-1:0] w);
        logic [W-1:0] old, seen;
        string req;
        case (sel)
            0: begin old = cur_a; req = "R1"; end
            1: begin old = cur_b; req = "R2"; end
            default: begin old = cur_m; req = "R3"; end
        endcase
        for (int i = W - 1; i >= 0; i--) begin
            @(negedge clk);
            case (sel)
                0: begin seen[i] = a_sout; a_in = w[i]; #1 clk_a = 1'b1; #1 clk_a = 1'b0; end
                1: begin seen[i] = b_sout; b_in = w[i]; #1 clk_b = 1'b1; #1 clk_b = 1'b0; end
                default: begin seen[i] = m_sout; m_in = w[i]; #1 clk_m = 1'b1; #1 clk_m = 1'b0; end
            endcase
        end
        check(seen == old, $sformatf("%s serial out act=%h exp=%h", req, seen, old));
        case (sel)
            0: cur_a = w;
            1: cur_b = w;
            default: cur_m = w;
        endcase
    endtask

    task automatic capture();
        @(negedge clk); load_c = 1'b1;
        @(negedge clk); load_c = 1'b0;
        cur_c = cur_b;
    endtask

    task automatic set_thr(input int v);
        @(negedge clk); thr_in = SW'(v); thr_load = 1'b1;
        @(negedge clk); thr_load = 1'b0;
        cur_thr = v;
    endtask

    task automatic check_score(input string req);
        int es;
        bit ef;
        @(negedge clk); @(negedge clk);
        es = model_score(cur_a, cur_c, cur_m);
        ef = (es >= cur_thr);
        check(int'(score_o) == es, $sformatf("%s score act=%0d exp=%0d", req, score_o, es));
        check(flag_o == ef, $sformatf("%s flag act=%0d exp=%0d", req, flag_o, ef));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [W-1:0] w;
        void'($urandom(32'h1357_2468));
        // R8: reset state
        repeat (3) @(negedge clk);
        check(score_o == '0 && flag_o == 1'b0,
              $sformatf("R8 reset score=%0d flag=%0d exp 0/0", score_o, flag_o));
        rst_n = 1'b1;
        // R9: zero mask, zero threshold gives flag 1
        check_score("R9");

        // R9: zero mask with data present, threshold 1
        w = {$urandom, $urandom};
        shift_word(0, w);
        shift_word(1, ~w);
        capture();
        set_thr(1);
        check_score("R9");

        // R5, R7: full match at every position
        shift_word(1, w);
        capture();
        shift_word(2, '1);
        set_thr(64);
        check_score("R5");
        check(score_o == 7'd64, $sformatf("R5 full score act=%0d exp=64", score_o));
        set_thr(65);
        check_score("R7");

        // R6: thr_in change without load has no effect
        @(negedge clk); thr_in = '0;
        check_score("R6");
        check(flag_o == 1'b0, $sformatf("R6 flag act=%0d exp=0", flag_o));

        // R4: new reference data without capture leaves score alone
        shift_word(1, {$urandom, $urandom});
        check_score("R4");
        check(score_o == 7'd64, $sformatf("R4 held score act=%0d exp=64", score_o));
        capture();
        check_score("R4");

        // Random mix, R1 R2 R3 R5 R7
        for (int k = 0; k < 14; k++) begin
            shift_word(0, {$urandom, $urandom});
            shift_word(1, (k % 3 == 0) ? cur_a ^ W'($urandom) : {$urandom, $urandom});
            shift_word(2, (k % 4 == 0) ? ~W'(0) >> ($urandom % 64) : {$urandom, $urandom});
            capture();
            set_thr(int'($urandom % 70));
            check_score("R5");
            set_thr(model_score(cur_a, cur_c, cur_m));
            check_score("R7");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule